// File: doc/BRIEF.md
# Receive Buffer Queue with Status Writeback

This block handles the receive-side buffer handling of an Ethernet MAC. Software hands free receive buffers to the hardware by pushing their base byte addresses into a small address FIFO. When a frame starts arriving, the block takes the oldest posted address and writes the frame's 64-bit data words into that buffer, beginning a configurable number of words past the base. One cycle after the last data word it writes a 64-bit status word at the buffer base. That word carries a valid flag, the received length including the 4-byte CRC, and error bits.

The block keeps an 8-bit read index that counts consumed buffers and a 5-bit sequence number that counts completed frames. It also holds an 8-bit interrupt flag register whose bits are cleared by writing ones. Bit 0 is the receive-threshold flag: it is raised once a programmed number of frames have completed since that flag was last cleared. Bit 1 is the no-buffer flag: it is raised when a frame arrives while DMA is enabled and no buffer is posted. Memory is modelled as a plain write port that always accepts a write. Frames must be separated by at least one idle input cycle, which leaves that cycle free for the status write.

Top module: `rx_buf_queue`

## Requirements
- R1: Posted buffers are consumed in the order they were posted, one per accepted frame, and `rd_index` increments by one (mod 256) for each consumed buffer.
- R2: Data word k of a frame (k from 0) is written unchanged to byte address base + 8*(cfg_offset + k), where cfg_offset counts 8-byte words. The write appears on the memory port one cycle after the word is presented.
- R3: One cycle after a frame's last data write, the status word is written to the buffer base. It has bit 63 = 1 and bits [15:0] = length in bytes including CRC = 8*(n-1) + b, where n is the word count and b is the valid byte count of the last word (code 0 means 8). Bits [62:19] are zero, and `rx_seq` increments by one (mod 32).
- R4: Status bit 16 is set when the frame was marked with a CRC error. Bit 17 is set when the length is below 64. Bit 18 is set when the length exceeds 1522, which is 1518 plus the CRC.
- R5: A frame that starts while DMA is enabled and no buffer is posted is dropped with no memory write, and interrupt flag bit 1 is set.
- R6: While `dma_en` is low, arriving frames are dropped without consuming a buffer, without any write and without setting a flag. Posts are still accepted.
- R7: With `irq_en` high and `cfg_thresh` nonzero, flag bit 0 is set when the number of frames completed since bit 0 was last cleared reaches `cfg_thresh`. With `irq_en` low it is never set. `irq` is high whenever any flag bit is set.
- R8: A `clr_valid` pulse clears every flag bit whose `clr_mask` bit is 1. A set event in the same cycle wins.
- R9: A post is ignored while the FIFO already holds `cfg_depth` entries, or `FIFO_DEPTH` entries.
- R10: After reset the flags, `irq`, `rd_index` and `rx_seq` are zero and no memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Push a free buffer address |
| post_addr | input | 32 | Buffer base byte address |
| cfg_depth | input | 5 | Usable FIFO depth |
| cfg_offset | input | 8 | Data start offset in 8-byte words |
| dma_en | input | 1 | Receive DMA enable |
| irq_en | input | 1 | Receive-threshold interrupt enable |
| cfg_thresh | input | 8 | Completed-frame threshold |
| frm_valid | input | 1 | Frame data word valid |
| frm_data | input | 64 | Frame data word |
| frm_last | input | 1 | Last word of frame |
| frm_lbytes | input | 3 | Valid bytes in last word, 0 means 8 |
| frm_crc_err | input | 1 | CRC failure marker, sampled with last word |
| clr_valid | input | 1 | Flag clear strobe |
| clr_mask | input | 8 | Write-one-to-clear mask |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| irq_flags | output | 8 | Interrupt flag register |
| irq | output | 1 | Interrupt request |
| rd_index | output | 8 | Consumed-buffer read index |
| rx_seq | output | 5 | Completed-frame sequence number |

## Verification
The hardest situation to reach is the boundary between a usable and an exhausted buffer supply. A frame has to start exactly when the FIFO is empty, or when the programmed depth rather than the physical one has turned a post away. The bench reaches this by lowering `cfg_depth` to two, posting three buffers and sending three frames, so the third finds no buffer. It also sends a frame with DMA disabled while a buffer is waiting, then enables DMA and confirms that the same buffer receives the next frame. Lengths of exactly 64, 1522 and 1523 bytes probe the error-bit edges.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int STAT_VALID_BIT = 63;
  localparam int STAT_CRC_BIT   = 16;
  localparam int STAT_RUNT_BIT  = 17;
  localparam int STAT_LONG_BIT  = 18;
  localparam int CRC_BYTES      = 4;
  localparam int MIN_LEN_NOCRC  = 60;
  localparam int MAX_LEN_NOCRC  = 1518;
  localparam int FLAG_THRESH    = 0;
  localparam int FLAG_NOBUF     = 1;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_RECV = 2'd1,
    WR_DROP = 2'd2
  } wr_state_t;
endpackage

// File: rtl/rxq_addr_fifo.sv
module rxq_addr_fifo #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [CW-1:0] lim,
  input  logic          pop,
  output logic [AW-1:0] head,
  output logic          empty
);
  logic [AW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push;

  assign do_push = push && (cnt < lim) && (cnt < CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign head    = store[rp];

  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)     rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/rxq_frame_writer.sv
module rxq_frame_writer
  import rxq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFFW = 8,
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frm_valid,
  input  logic [63:0]     frm_data,
  input  logic            frm_last,
  input  logic [2:0]      frm_lbytes,
  input  logic            frm_crc_err,
  input  logic            dma_en,
  input  logic [OFFW-1:0] cfg_offset,
  input  logic            fifo_empty,
  input  logic [AW-1:0]   fifo_head,
  output logic            pop,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [63:0]     mem_wdata,
  output logic            status_done,
  output logic            drop_nobuf
);
  wr_state_t     st;
  logic [AW-1:0] base_q;
  logic [LENW-1:0] widx;
  logic          stat_pend;
  logic [63:0]   stat_word;

  logic            start, accept, take;
  logic [AW-1:0]   cur_base;
  logic [LENW-1:0] cur_idx;
  logic [LENW-1:0] len_now;
  logic [3:0]      lb8;
  logic [63:0]     stat_next;

  assign start    = frm_valid && (st == WR_IDLE);
  assign accept   = start && dma_en && !fifo_empty;
  assign take     = frm_valid && ((st == WR_RECV) || accept);
  assign pop      = accept;
  assign cur_base = accept ? fifo_head : base_q;
  assign cur_idx  = accept ? '0 : widx;
  assign lb8      = (frm_lbytes == 3'd0) ? 4'd8 : {1'b0, frm_lbytes};
  assign len_now  = {cur_idx[LENW-4:0], 3'b000} + LENW'(lb8);

  always_comb begin
    stat_next = '0;
    stat_next[STAT_VALID_BIT] = 1'b1;
    stat_next[LENW-1:0]       = len_now;
    stat_next[STAT_CRC_BIT]   = frm_crc_err;
    stat_next[STAT_RUNT_BIT]  = len_now < LENW'(MIN_LEN_NOCRC + CRC_BYTES);
    stat_next[STAT_LONG_BIT]  = len_now > LENW'(MAX_LEN_NOCRC + CRC_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= WR_IDLE;
      base_q      <= '0;
      widx        <= '0;
      stat_pend   <= 1'b0;
      stat_word   <= '0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      status_done <= 1'b0;
      drop_nobuf  <= 1'b0;
    end else begin
      status_done <= 1'b0;
      drop_nobuf  <= 1'b0;
      mem_we      <= 1'b0;
      if (stat_pend) begin
        mem_we      <= 1'b1;
        mem_addr    <= base_q;
        mem_wdata   <= stat_word;
        stat_pend   <= 1'b0;
        status_done <= 1'b1;
      end else if (take) begin
        mem_we    <= 1'b1;
        mem_addr  <= cur_base + (AW'(cfg_offset) + AW'(cur_idx)) * AW'(8);
        mem_wdata <= frm_data;
      end
      if (take) begin
        base_q <= cur_base;
        widx   <= cur_idx + 1'b1;
        if (frm_last) begin
          st        <= WR_IDLE;
          stat_pend <= 1'b1;
          stat_word <= stat_next;
        end else begin
          st <= WR_RECV;
        end
      end else if (start) begin
        drop_nobuf <= dma_en;
        st         <= frm_last ? WR_IDLE : WR_DROP;
      end else if (st == WR_DROP && frm_valid && frm_last) begin
        st <= WR_IDLE;
      end
    end
  end

  p_gap_before_start_r3: assert property (@(posedge clk) disable iff (rst)
    stat_pend |-> !(frm_valid && st == WR_IDLE));
  p_status_after_data_r3: assert property (@(posedge clk) disable iff (rst)
    status_done |-> $past(mem_we));
  p_no_pop_dma_off_r6: assert property (@(posedge clk) disable iff (rst)
    pop |-> dma_en);
  p_status_valid_r3: assert property (@(posedge clk) disable iff (rst)
    status_done |-> mem_wdata[STAT_VALID_BIT]);
endmodule

// File: rtl/rxq_irq_status.sv
module rxq_irq_status
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       status_done,
  input  logic       drop_nobuf,
  input  logic       pop,
  input  logic       irq_en,
  input  logic [7:0] cfg_thresh,
  input  logic       clr_valid,
  input  logic [7:0] clr_mask,
  output logic [7:0] irq_flags,
  output logic       irq,
  output logic [7:0] rd_index,
  output logic [4:0] rx_seq
);
  logic [7:0] done_cnt, cnt_base, cnt_next;
  logic [7:0] clr_bits, set_bits, flags_next;

  assign clr_bits = clr_valid ? clr_mask : 8'h00;
  assign cnt_base = clr_bits[FLAG_THRESH] ? 8'h00 : done_cnt;
  assign cnt_next = (status_done && cnt_base != 8'hFF) ? cnt_base + 1'b1 : cnt_base;

  always_comb begin
    set_bits = 8'h00;
    set_bits[FLAG_THRESH] = status_done && irq_en && (cfg_thresh != 8'h00)
                            && (cnt_next >= cfg_thresh);
    set_bits[FLAG_NOBUF]  = drop_nobuf;
  end

  assign flags_next = (irq_flags & ~clr_bits) | set_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_cnt  <= '0;
      irq_flags <= '0;
      irq       <= 1'b0;
      rd_index  <= '0;
      rx_seq    <= '0;
    end else begin
      done_cnt  <= cnt_next;
      irq_flags <= flags_next;
      irq       <= |flags_next;
      if (pop)         rd_index <= rd_index + 1'b1;
      if (status_done) rx_seq   <= rx_seq + 1'b1;
    end
  end

  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    status_done |=> rx_seq == $past(rx_seq) + 5'd1);
  p_clear_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && clr_mask[FLAG_NOBUF] && !drop_nobuf) |=> !irq_flags[FLAG_NOBUF]);
  p_irq_any_r7: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_flags != 8'h00));
  p_no_thresh_off_r7: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && !irq_flags[FLAG_THRESH]) |=> !irq_flags[FLAG_THRESH]);
endmodule

// File: rtl/rx_buf_queue.sv
module rx_buf_queue #(
  parameter int AW         = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int OFFW       = 8,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          post_valid,
  input  logic [AW-1:0] post_addr,
  input  logic [CW-1:0] cfg_depth,
  input  logic [OFFW-1:0] cfg_offset,
  input  logic          dma_en,
  input  logic          irq_en,
  input  logic [7:0]    cfg_thresh,
  input  logic          frm_valid,
  input  logic [63:0]   frm_data,
  input  logic          frm_last,
  input  logic [2:0]    frm_lbytes,
  input  logic          frm_crc_err,
  input  logic          clr_valid,
  input  logic [7:0]    clr_mask,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  output logic [7:0]    irq_flags,
  output logic          irq,
  output logic [7:0]    rd_index,
  output logic [4:0]    rx_seq
);
  logic          pop, fifo_empty, status_done, drop_nobuf;
  logic [AW-1:0] fifo_head;

  rxq_addr_fifo #(.AW(AW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(post_valid), .push_addr(post_addr),
    .lim(cfg_depth), .pop(pop), .head(fifo_head), .empty(fifo_empty)
  );

  rxq_frame_writer #(.AW(AW), .OFFW(OFFW)) u_writer (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_last(frm_last), .frm_lbytes(frm_lbytes), .frm_crc_err(frm_crc_err),
    .dma_en(dma_en), .cfg_offset(cfg_offset), .fifo_empty(fifo_empty),
    .fifo_head(fifo_head), .pop(pop), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .status_done(status_done), .drop_nobuf(drop_nobuf)
  );

  rxq_irq_status u_irq (
    .clk(clk), .rst(rst), .status_done(status_done), .drop_nobuf(drop_nobuf),
    .pop(pop), .irq_en(irq_en), .cfg_thresh(cfg_thresh), .clr_valid(clr_valid),
    .clr_mask(clr_mask), .irq_flags(irq_flags), .irq(irq),
    .rd_index(rd_index), .rx_seq(rx_seq)
  );

  p_reset_quiet_r10: assert property (@(posedge clk) rst |=> !mem_we && irq_flags == 8'h00);
endmodule

// File: tb/test_rx_buf_queue.sv
module test_rx_buf_queue;
  logic        clk = 1'b0;
  logic        rst;
  logic        post_valid;
  logic [31:0] post_addr;
  logic [4:0]  cfg_depth;
  logic [7:0]  cfg_offset;
  logic        dma_en, irq_en;
  logic [7:0]  cfg_thresh;
  logic        frm_valid;
  logic [63:0] frm_data;
  logic        frm_last;
  logic [2:0]  frm_lbytes;
  logic        frm_crc_err;
  logic        clr_valid;
  logic [7:0]  clr_mask;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  irq_flags;
  logic        irq;
  logic [7:0]  rd_index;
  logic [4:0]  rx_seq;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  logic [31:0] log_addr [2048];
  logic [63:0] log_data [2048];
  int exp_rd  = 0;
  int exp_seq = 0;

  always #4 clk = ~clk;

  rx_buf_queue i_rx_buf_queue (
    .clk(clk), .rst(rst), .post_valid(post_valid), .post_addr(post_addr),
    .cfg_depth(cfg_depth), .cfg_offset(cfg_offset), .dma_en(dma_en),
    .irq_en(irq_en), .cfg_thresh(cfg_thresh), .frm_valid(frm_valid),
    .frm_data(frm_data), .frm_last(frm_last), .frm_lbytes(frm_lbytes),
    .frm_crc_err(frm_crc_err), .clr_valid(clr_valid), .clr_mask(clr_mask),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .irq_flags(irq_flags), .irq(irq), .rd_index(rd_index), .rx_seq(rx_seq)
  );

  always @(negedge clk) begin
    if (!rst && mem_we && wr_cnt < 2048) begin
      log_addr[wr_cnt] = mem_addr;
      log_data[wr_cnt] = mem_data_copy(mem_wdata);
      wr_cnt = wr_cnt + 1;
    end
  end

  function automatic logic [63:0] mem_data_copy(input logic [63:0] d);
    return d;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic post(input logic [31:0] a);
    @(negedge clk);
    post_valid = 1'b1; post_addr = a;
    @(negedge clk);
    post_valid = 1'b0;
  endtask

  task automatic clear_flags(input logic [7:0] m);
    @(negedge clk);
    clr_valid = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_valid = 1'b0; clr_mask = 8'h00;
    idle(1);
  endtask

  function automatic logic [63:0] word_of(input int seed, input int k);
    return {16'hC0DE, 16'(seed), 32'(k)};
  endfunction

  task automatic send(input int n, input int lb, input bit crc, input int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frm_valid = 1'b1; frm_data = word_of(seed, k);
      frm_last = (k == n - 1); frm_lbytes = 3'(lb); frm_crc_err = crc;
    end
    @(negedge clk);
    frm_valid = 1'b0; frm_last = 1'b0; frm_crc_err = 1'b0;
    idle(3);
  endtask

  task automatic frame_into(input string req, input logic [31:0] base, input int n,
                            input int lb, input bit crc, input int seed);
    int s;
    int len;
    logic [63:0] st;
    bit data_ok;
    s = wr_cnt;
    send(n, lb, crc, seed);
    exp_rd++; exp_seq++;
    check({req, " write count"}, 64'(wr_cnt - s), 64'(n + 1));
    data_ok = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (log_addr[s + k] !== base + 32'((cfg_offset + k) * 8) ||
          log_data[s + k] !== word_of(seed, k)) data_ok = 1'b0;
    end
    check({req, " R2 data placement"}, 64'(data_ok), 64'd1);
    len = 8 * (n - 1) + ((lb == 0) ? 8 : lb);
    st = 64'(len);
    st[63] = 1'b1;
    st[16] = crc;
    st[17] = (len < 64);
    st[18] = (len > 1522);
    check({req, " R3 status addr"}, 64'(log_addr[s + n]), 64'(base));
    check({req, " R3/R4 status word"}, log_data[s + n], st);
    check({req, " R1 rd_index"}, 64'(rd_index), 64'(exp_rd % 256));
    check({req, " R3 rx_seq"}, 64'(rx_seq), 64'(exp_seq % 32));
  endtask

  task automatic t_reset;
    check("R10 flags", 64'(irq_flags), 64'h0);
    check("R10 irq", 64'(irq), 64'h0);
    check("R10 rd_index", 64'(rd_index), 64'h0);
    check("R10 rx_seq", 64'(rx_seq), 64'h0);
    check("R10 no writes", 64'(wr_cnt), 64'h0);
  endtask

  task automatic t_basic;
    post(32'h0000_1000);
    frame_into("R2 basic", 32'h0000_1000, 9, 4, 1'b0, 1);
  endtask

  task automatic t_order;
    post(32'h0000_2000);
    post(32'h0000_3000);
    frame_into("R1 first", 32'h0000_2000, 8, 0, 1'b0, 2);
    frame_into("R4 runt crc", 32'h0000_3000, 3, 1, 1'b1, 3);
  endtask

  task automatic t_lengths;
    post(32'h0000_4000);
    post(32'h0001_0000);
    frame_into("R4 1523", 32'h0000_4000, 191, 3, 1'b0, 4);
    frame_into("R4 1522", 32'h0001_0000, 191, 2, 1'b0, 5);
  endtask

  task automatic t_empty;
    int s;
    s = wr_cnt;
    send(4, 0, 1'b0, 6);
    check("R5 no writes", 64'(wr_cnt - s), 64'd0);
    check("R5 nobuf flag", 64'(irq_flags), 64'h02);
    check("R5 irq", 64'(irq), 64'h1);
    check("R5 rd_index", 64'(rd_index), 64'(exp_rd % 256));
    clear_flags(8'h02);
    check("R8 cleared", 64'(irq_flags), 64'h00);
    check("R8 irq low", 64'(irq), 64'h0);
  endtask

  task automatic t_dma_off;
    int s;
    dma_en = 1'b0;
    post(32'h0000_6000);
    s = wr_cnt;
    send(3, 0, 1'b0, 7);
    check("R6 no writes", 64'(wr_cnt - s), 64'd0);
    check("R6 no flag", 64'(irq_flags), 64'h00);
    check("R6 rd_index", 64'(rd_index), 64'(exp_rd % 256));
    dma_en = 1'b1;
    frame_into("R6 buffer kept", 32'h0000_6000, 2, 0, 1'b0, 8);
  endtask

  task automatic t_thresh;
    irq_en = 1'b1; cfg_thresh = 8'd3;
    clear_flags(8'h01);
    post(32'h0000_7000); post(32'h0000_7800); post(32'h0000_8000);
    frame_into("R7 t1", 32'h0000_7000, 8, 0, 1'b0, 9);
    frame_into("R7 t2", 32'h0000_7800, 8, 0, 1'b0, 10);
    check("R7 below threshold", 64'(irq_flags), 64'h00);
    frame_into("R7 t3", 32'h0000_8000, 8, 0, 1'b0, 11);
    check("R7 threshold flag", 64'(irq_flags), 64'h01);
    check("R7 irq", 64'(irq), 64'h1);
    clear_flags(8'h01);
    check("R8 threshold cleared", 64'(irq_flags), 64'h00);
    irq_en = 1'b0; cfg_thresh = 8'd1;
    post(32'h0000_8800);
    frame_into("R7 disabled", 32'h0000_8800, 8, 0, 1'b0, 12);
    check("R7 no flag when disabled", 64'(irq_flags), 64'h00);
  endtask

  task automatic t_depth;
    int s;
    cfg_depth = 5'd2;
    post(32'h0000_9000); post(32'h0000_A000); post(32'h0000_B000);
    frame_into("R9 d1", 32'h0000_9000, 8, 0, 1'b0, 13);
    frame_into("R9 d2", 32'h0000_A000, 8, 0, 1'b0, 14);
    s = wr_cnt;
    send(8, 0, 1'b0, 15);
    check("R9 third post ignored", 64'(wr_cnt - s), 64'd0);
    check("R9 nobuf flag", 64'(irq_flags), 64'h02);
  endtask

  initial begin
    rst = 1'b1; post_valid = 1'b0; post_addr = '0; cfg_depth = 5'd16;
    cfg_offset = 8'd2; dma_en = 1'b1; irq_en = 1'b0; cfg_thresh = 8'd0;
    frm_valid = 1'b0; frm_data = '0; frm_last = 1'b0; frm_lbytes = '0;
    frm_crc_err = 1'b0; clr_valid = 1'b0; clr_mask = '0;
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_basic();
    t_order();
    t_lengths();
    t_empty();
    t_dma_off();
    t_thresh();
    t_depth();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule